// File: doc/BRIEF.md
# Address-Pattern Bank Switch Unit

This unit sits on a bytewide memory bus and chooses which 32K-byte bank of a larger memory answers the host. The host has no bank register it can write. It selects a bank through a hidden handshake made of read cycles: one priming read with all four watched address lines high, then sixteen reads whose values on those four lines must follow a fixed pattern. In the last five of those reads, the lowest watched line carries a five-bit select code. Every other address line is ignored.

The bus strobes and the watched address lines are brought into the system clock domain through a synchronizer. A read cycle counts once, when chip enable is released. Any mismatch sends the sequencer back to idle and leaves the current bank as it was. When power is not good, no bank is active, so several units can share one bus. The fixed pattern, the select-code table and the number of installed banks are all parameters.

Top module: `bank_pat_switch`

## Requirements
- R1: After reset, bank_act_o is 0 and bank_o is 0. Whenever bank_act_o is 0, bank_o is 0.
- R2: While pwr_ok_i is low, bank_act_o is 0 from the next clock edge, reads are ignored, and any partly entered sequence is discarded.
- R3: A read of 4'b1111 on pat_addr_i (bit 0 is the lowest watched line) arms the sequencer. Without it, a correct 16-read sequence changes nothing.
- R4: After arming, 16 matching reads select a bank. The change becomes visible only after the 16th read completes, and never after 15.
- R5: In steps 0 to 10, all four bits must equal FIX_PAT[4k+3:4k]. A difference in any bit returns the sequencer to idle with the bank unchanged.
- R6: In steps 11 to 15, pat_addr_i[3:1] must equal FIX_TAIL[3j+2:3j] (j = step-11), and pat_addr_i[0] is taken as bit j of the select code.
- R7: A code equal to entry b of SEL_TAB selects bank b (the default maps 5'b1bbbb to bank bbbb). A code that is in no entry, or that selects a bank b >= NUM_BANKS, deselects all banks.
- R8: A cycle with we_ni low at any time while ce_ni is low is not a pattern step and does not break a sequence in progress.
- R9: After a mismatch, a new all-ones read is needed before matching starts again.
- R10: A selected bank stays active until another selection, a deselect, or a power loss. A new selection replaces it.
- R11: A read is counted once, when ce_ni rises, using the last pat_addr_i sampled while ce_ni was low. The result appears on the third rising clock edge after ce_ni rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Supply good, synchronous to clk_i |
| ce_ni | input | 1 | Active-low chip enable strobe |
| we_ni | input | 1 | Active-low write enable strobe |
| pat_addr_i | input | 4 | Watched address lines, bit 0 lowest |
| bank_o | output | 4 | Index of the active bank |
| bank_act_o | output | 1 | A bank is selected |

## Verification
The hardest state to reach from the ports is a sequencer that is partway through the pattern at the moment power drops. If the discard does not happen, the remaining reads would complete a valid selection that nobody intended. The bench primes the unit, feeds half the pattern, pulses pwr_ok_i low, and then feeds the rest. It also corrupts single bits at chosen steps, injects write cycles in the middle of a sequence, and runs sequences without priming. In every case the bank state is checked at the ports after the last read.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  localparam int NIB_W     = 4;
  localparam int STEP_N    = 16;
  localparam int FULL_N    = 11;
  localparam int TAIL_N    = STEP_N - FULL_N;
  localparam int CODE_W    = TAIL_N;
  localparam int MAX_BANKS = 16;
  localparam int BANK_W    = $clog2(MAX_BANKS);

  typedef struct packed {
    logic              act;
    logic [BANK_W-1:0] idx;
  } bank_sel_t;

  function automatic logic [MAX_BANKS*CODE_W-1:0] default_sel_tab();
    logic [MAX_BANKS*CODE_W-1:0] t;
    t = '0;
    for (int b = 0; b < MAX_BANKS; b++) t[CODE_W*b +: CODE_W] = CODE_W'(MAX_BANKS + b);
    return t;
  endfunction
endpackage

// File: rtl/bsw_bus_sync.sv
module bsw_bus_sync import bsw_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             we_ni,
  input  logic [NIB_W-1:0] addr_i,
  output logic             rd_evt_o,
  output logic [NIB_W-1:0] rd_addr_o
);
  logic [SYNC_STAGES-1:0] ce_sr, we_sr;
  logic [NIB_W-1:0]       a_sr [SYNC_STAGES];
  logic                   ce_d, wr_seen_q;
  logic [NIB_W-1:0]       addr_q;
  logic                   ce_s, we_s;

  assign ce_s = ce_sr[SYNC_STAGES-1];
  assign we_s = we_sr[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_sr <= '1;
      we_sr <= '1;
      for (int i = 0; i < SYNC_STAGES; i++) a_sr[i] <= '0;
    end else begin
      ce_sr <= {ce_sr[SYNC_STAGES-2:0], ce_ni};
      we_sr <= {we_sr[SYNC_STAGES-2:0], we_ni};
      a_sr[0] <= addr_i;
      for (int i = 1; i < SYNC_STAGES; i++) a_sr[i] <= a_sr[i-1];
    end
  end

  // capture strobe history while the cycle is open
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_d      <= 1'b1;
      wr_seen_q <= 1'b0;
      addr_q    <= '0;
    end else begin
      ce_d      <= ce_s;
      wr_seen_q <= ce_s ? 1'b0 : (wr_seen_q | ~we_s);
      if (!ce_s) addr_q <= a_sr[SYNC_STAGES-1];
    end
  end

  assign rd_evt_o  = ce_s & ~ce_d & ~wr_seen_q;
  assign rd_addr_o = addr_q;

  a_r11_single_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt_o |=> !rd_evt_o);
endmodule

// File: rtl/bsw_pat_seq.sv
module bsw_pat_seq import bsw_pkg::*; #(
  parameter logic [FULL_N*NIB_W-1:0]       FIX_PAT  = 44'h5A3_C96E_1B72,
  parameter logic [TAIL_N*(NIB_W-1)-1:0]   FIX_TAIL = 15'h1A5C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              evt_i,
  input  logic [NIB_W-1:0]  addr_i,
  output logic              commit_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int STEP_W = $clog2(STEP_N);

  logic              armed_q;
  logic [STEP_W-1:0] step_q;
  logic [CODE_W-2:0] code_q;
  logic              in_tail, match, last;
  logic [3:0]        full_idx;
  logic [2:0]        tail_idx;
  logic [NIB_W-1:0]  exp_nib;
  logic [NIB_W-2:0]  exp_tail;

  assign in_tail  = step_q >= STEP_W'(FULL_N);
  assign full_idx = in_tail ? 4'd0 : 4'(step_q);
  assign tail_idx = in_tail ? 3'(step_q - STEP_W'(FULL_N)) : 3'd0;
  assign exp_nib  = FIX_PAT[NIB_W*full_idx +: NIB_W];
  assign exp_tail = FIX_TAIL[(NIB_W-1)*tail_idx +: (NIB_W-1)];
  assign match    = in_tail ? (addr_i[NIB_W-1:1] == exp_tail) : (addr_i == exp_nib);
  assign last     = step_q == STEP_W'(STEP_N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      step_q  <= '0;
      code_q  <= '0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      step_q  <= '0;
    end else if (evt_i) begin
      if (!armed_q) begin
        armed_q <= &addr_i;
        step_q  <= '0;
      end else if (!match || last) begin
        armed_q <= 1'b0;
        step_q  <= '0;
      end else begin
        step_q <= step_q + 1'b1;
        if (in_tail) code_q[tail_idx[1:0]] <= addr_i[0];
      end
    end
  end

  assign commit_o = evt_i & ~clr_i & armed_q & match & last;
  assign code_o   = {addr_i[0], code_q};

  a_r5_mismatch_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && armed_q && !match) |=> !armed_q);
  a_r11_step_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !clr_i) |=> ($stable(step_q) && $stable(armed_q)));
endmodule

// File: rtl/bsw_sel_decode.sv
module bsw_sel_decode import bsw_pkg::*; #(
  parameter int                             NUM_BANKS = 16,
  parameter logic [MAX_BANKS*CODE_W-1:0]    SEL_TAB   = default_sel_tab()
) (
  input  logic [CODE_W-1:0] code_i,
  output bank_sel_t         sel_o
);
  logic              hit;
  logic [BANK_W-1:0] idx;

  // lowest matching entry wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int b = MAX_BANKS - 1; b >= 0; b--) begin
      if (SEL_TAB[CODE_W*b +: CODE_W] == code_i) begin
        hit = 1'b1;
        idx = BANK_W'(b);
      end
    end
  end

  assign sel_o.act = hit && ({1'b0, idx} < (BANK_W+1)'(NUM_BANKS));
  assign sel_o.idx = sel_o.act ? idx : '0;
endmodule

// File: rtl/bank_pat_switch.sv
module bank_pat_switch import bsw_pkg::*; #(
  parameter int                             NUM_BANKS   = 16,
  parameter int                             SYNC_STAGES = 2,
  parameter logic [FULL_N*NIB_W-1:0]        FIX_PAT     = 44'h5A3_C96E_1B72,
  parameter logic [TAIL_N*(NIB_W-1)-1:0]    FIX_TAIL    = 15'h1A5C,
  parameter logic [MAX_BANKS*CODE_W-1:0]    SEL_TAB     = default_sel_tab()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [NIB_W-1:0]  pat_addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              bank_act_o
);
  logic              rd_evt, commit;
  logic [NIB_W-1:0]  rd_addr;
  logic [CODE_W-1:0] code;
  bank_sel_t         sel, bank_q;

  bsw_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .addr_i(pat_addr_i),
    .rd_evt_o(rd_evt), .rd_addr_o(rd_addr)
  );

  bsw_pat_seq #(.FIX_PAT(FIX_PAT), .FIX_TAIL(FIX_TAIL)) u_seq (
    .clk_i, .rst_ni, .clr_i(~pwr_ok_i), .evt_i(rd_evt & pwr_ok_i),
    .addr_i(rd_addr), .commit_o(commit), .code_o(code)
  );

  bsw_sel_decode #(.NUM_BANKS(NUM_BANKS), .SEL_TAB(SEL_TAB)) u_dec (
    .code_i(code), .sel_o(sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bank_q <= '0;
    else if (!pwr_ok_i) bank_q <= '0;
    else if (commit)    bank_q <= sel;
  end

  assign bank_o     = bank_q.idx;
  assign bank_act_o = bank_q.act;

  a_r2_pwr_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> !bank_act_o);
  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_act_o |-> bank_o == '0);
  a_r7_installed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_act_o |-> ({1'b0, bank_o} < (BANK_W+1)'(NUM_BANKS)));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_ok_i && !commit) |=> ($stable(bank_o) && $stable(bank_act_o)));
endmodule

// File: tb/bank_pat_switch_tb.sv
module bank_pat_switch_tb_top;
  localparam int NB = 12;
  localparam logic [43:0] PAT  = 44'h5A3_C96E_1B72;
  localparam logic [14:0] TAIL = 15'h1A5C;
  localparam int NONE = 31;

  // {prime, code[4:0], bad_step[4:0], mask[3:0], wr_ins, exp_act, exp_bank[3:0]}
  localparam logic [20:0] SCN [10] = '{
    {1'b1, 5'd21, 5'd31, 4'h0, 1'b0, 1'b1, 4'd5},   // R4 select bank 5
    {1'b0, 5'd19, 5'd31, 4'h0, 1'b0, 1'b1, 4'd5},   // R3 no priming read
    {1'b1, 5'd25, 5'd4,  4'h8, 1'b0, 1'b1, 4'd5},   // R5 A11 wrong at step 4
    {1'b1, 5'd25, 5'd0,  4'h1, 1'b0, 1'b1, 4'd5},   // R5 A8 wrong at step 0
    {1'b1, 5'd18, 5'd12, 4'h4, 1'b0, 1'b1, 4'd5},   // R6 A10 wrong at step 12
    {1'b1, 5'd25, 5'd31, 4'h0, 1'b1, 1'b1, 4'd9},   // R8 R10 write inside sequence
    {1'b1, 5'd30, 5'd31, 4'h0, 1'b0, 1'b0, 4'd0},   // R7 bank 14 not installed
    {1'b1, 5'd27, 5'd31, 4'h0, 1'b0, 1'b1, 4'd11},  // R6 A8 carries code
    {1'b1, 5'd3,  5'd31, 4'h0, 1'b0, 1'b0, 4'd0},   // R7 code not in table
    {1'b1, 5'd16, 5'd31, 4'h0, 1'b0, 1'b1, 4'd0}    // R10 bank 0
  };

  logic       clk_i = 1'b0, rst_ni = 1'b0, pwr_ok_i = 1'b1;
  logic       ce_ni = 1'b1, we_ni = 1'b1;
  logic [3:0] pat_addr_i = 4'h0;
  logic [3:0] bank_o;
  logic       bank_act_o;
  int n_run = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  bank_pat_switch #(.NUM_BANKS(NB), .FIX_PAT(PAT), .FIX_TAIL(TAIL)) dut_i (
    .clk_i, .rst_ni, .pwr_ok_i, .ce_ni, .we_ni, .pat_addr_i, .bank_o, .bank_act_o
  );

  task automatic chk(string req, logic ea, logic [3:0] eb);
    n_run++;
    if (bank_act_o !== ea || (ea && bank_o !== eb) || (!ea && bank_o !== 4'd0)) begin
      n_fail++;
      $display("FAIL %s: act=%0b bank=%0d expected act=%0b bank=%0d",
               req, bank_act_o, bank_o, ea, ea ? eb : 4'd0);
    end
  endtask

  function automatic logic [3:0] nib_for(int k, logic [4:0] code);
    if (k < 11) return PAT[4*k +: 4];
    return {TAIL[3*(k-11) +: 3], code[k-11]};
  endfunction

  task automatic bus_cycle(logic wr, logic [3:0] a);
    @(negedge clk_i);
    pat_addr_i = a; ce_ni = 1'b0; we_ni = ~wr;
    repeat (3) @(negedge clk_i);
    ce_ni = 1'b1;
    @(negedge clk_i);
    we_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic run_seq(logic prime, logic [4:0] code, int bad, logic [3:0] mask, logic wr_ins);
    if (prime) bus_cycle(1'b0, 4'hF);
    for (int k = 0; k < 16; k++) begin
      if (wr_ins && k == 5) bus_cycle(1'b1, 4'hF);
      bus_cycle(1'b0, nib_for(k, code) ^ ((k == bad) ? mask : 4'h0));
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: act=%0b bank=%0d expected completion", bank_act_o, bank_o);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", 1'b0, 4'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 after reset", 1'b0, 4'd0);

    for (int s = 0; s < 10; s++) begin
      logic [20:0] v;
      v = SCN[s];
      run_seq(v[20], v[19:15], (v[14:10] == 5'(NONE)) ? NONE : int'(v[14:10]), v[9:6], v[5]);
      chk($sformatf("R3-R10 table %0d", s), v[4], v[3:0]);
    end

    // R9: mismatch followed by the pattern without a fresh priming read
    bus_cycle(1'b0, 4'hF);
    bus_cycle(1'b0, nib_for(0, 5'd17));
    bus_cycle(1'b0, 4'h0);
    run_seq(1'b0, 5'd17, NONE, 4'h0, 1'b0);
    chk("R9 no re-prime", 1'b1, 4'd0);
    run_seq(1'b1, 5'd17, NONE, 4'h0, 1'b0);
    chk("R9 re-primed", 1'b1, 4'd1);

    // R2: power loss
    @(negedge clk_i); pwr_ok_i = 1'b0;
    @(negedge clk_i);
    chk("R2 drop", 1'b0, 4'd0);
    run_seq(1'b1, 5'd20, NONE, 4'h0, 1'b0);
    chk("R2 reads ignored", 1'b0, 4'd0);
    pwr_ok_i = 1'b1;
    run_seq(1'b1, 5'd20, NONE, 4'h0, 1'b0);
    chk("R2 recover", 1'b1, 4'd4);
    bus_cycle(1'b0, 4'hF);
    for (int k = 0; k < 8; k++) bus_cycle(1'b0, nib_for(k, 5'd23));
    pwr_ok_i = 1'b0;
    repeat (2) @(negedge clk_i);
    pwr_ok_i = 1'b1;
    for (int k = 8; k < 16; k++) bus_cycle(1'b0, nib_for(k, 5'd23));
    chk("R2 partial sequence discarded", 1'b0, 4'd0);

    // R4 and R11: only the 16th completed read switches, on the third edge
    bus_cycle(1'b0, 4'hF);
    for (int k = 0; k < 15; k++) bus_cycle(1'b0, nib_for(k, 5'd22));
    chk("R4 after 15 reads", 1'b0, 4'd0);
    @(negedge clk_i);
    pat_addr_i = nib_for(15, 5'd22); ce_ni = 1'b0;
    repeat (12) @(negedge clk_i);
    chk("R11 long cycle still open", 1'b0, 4'd0);
    ce_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 edge 1", 1'b0, 4'd0);
    @(negedge clk_i);
    chk("R11 edge 2", 1'b0, 4'd0);
    @(negedge clk_i);
    chk("R11 edge 3", 1'b1, 4'd6);
    repeat (10) @(negedge clk_i);
    chk("R10 held", 1'b1, 4'd6);

    finish_run();
  end
endmodule